// File: doc/BRIEF.md
# Serial Flash Erase/Program Sequencer

This block sits on the host side of a serial flash device that uses a page and buffer organisation. It takes one request at a time. A request names an operation, a page number, a buffer choice and a start offset inside the buffer. The operation is an erase of one page, an erase of an aligned group of eight pages, or a program of one page through one of the device's two buffers. The block builds the command frame for the operation and shifts it out, most significant bit first, in SPI mode 0. For a program, it then streams the payload bytes that arrive on a valid/ready interface.

When the last bit has been sent, the sequencer raises chip select, and this tells the device to start its self-timed operation. The sequencer then watches the device's busy pin. When busy clears, it gives a one-cycle `done` pulse. If busy stays high for longer than a parameterised number of cycles, it gives a `timeout_err` pulse and returns to idle.

Top module: `flash_erase_prog_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, `req_ready` is 1, and `dat_ready`, `done` and `timeout_err` are 0.
- R2: The `req_cmd` encoding is 0 for a single-page erase, 1 for an eight-page erase, and 2 or 3 for a program. A single-page erase sends 32 bits in this order: the byte 0x81, five 0 bits, the 10-bit page number, then nine 0 bits.
- R3: An eight-page erase sends 32 bits in this order: the byte 0x50, five 0 bits, page bits [9:3], then twelve 0 bits. Page bits [2:0] are ignored.
- R4: A program sends 0x82 when `req_buf`=0, or 0x85 when `req_buf`=1. It follows this with five 0 bits, the 10-bit page, the 9-bit offset and one 0 bit, for 33 bits in total. Each payload byte is then sent MSB first, in the order it was accepted.
- R5: SPI mode 0 applies. `spi_sck` is low whenever `spi_cs_n` is high, and `spi_mosi` does not change while `spi_sck` is high. Each half period of `spi_sck` lasts `SCK_DIV` clock cycles.
- R6: A byte is taken on a cycle where `dat_valid` and `dat_ready` are both high. `dat_ready` rises only between bytes of a program, with chip select low. The byte that carries `dat_last`=1 ends the stream. Gaps in `dat_valid` are allowed.
- R7: Chip select falls exactly once per operation. It stays low for the whole frame and payload, and rises only after the final bit has been clocked.
- R8: A request is taken only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from that cycle until `done` or `timeout_err` is pulsed.
- R9: After chip select rises, `done` pulses for exactly one cycle. This happens in the first cycle after a clock edge on which `flash_busy` was seen low.
- R10: If `flash_busy` is still high `TIMEOUT_CYCLES` cycles after chip select rises, `timeout_err` pulses for one cycle. In that case `done` is not pulsed, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cmd | input | 2 | 0 page erase, 1 eight-page erase, 2/3 program |
| req_page | input | PAGE_W | Page number |
| req_buf | input | 1 | Buffer select for program (0 or 1) |
| req_offset | input | OFS_W | Start byte inside the buffer |
| dat_valid | input | 1 | Payload byte offered |
| dat_ready | output | 1 | Payload byte can be taken |
| dat_byte | input | 8 | Payload byte |
| dat_last | input | 1 | Marks the final payload byte |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| flash_busy | input | 1 | Device busy indication |
| done | output | 1 | One-cycle pulse: operation finished |
| timeout_err | output | 1 | One-cycle pulse: busy did not clear in time |

## Verification
The embedded assertions check the rules that must hold on every cycle. They cover the mode-0 relation between `spi_sck`, `spi_mosi` and chip select, and the rule that `dat_ready` is only high with chip select low. They also check that `done` and `timeout_err` never coincide, that `done` follows a busy-low sample, and that an accepted request drops `req_ready` on the next cycle. Some properties can only be shown by the bench's scenarios. These are the exact bit content and length of each frame type, the ignored low page bits of an eight-page erase, and the payload order under random valid gaps. They also include the single chip-select window per operation, the exact `done` cycle after busy falls, and the exact `timeout_err` delay.

// File: rtl/flash_erase_prog_seq.sv
module flash_erase_prog_seq #(
  parameter int SCK_DIV        = 2,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int PAGE_W         = 10,
  parameter int OFS_W          = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cmd,
  input  logic [PAGE_W-1:0] req_page,
  input  logic              req_buf,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [7:0]        dat_byte,
  input  logic              dat_last,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              flash_busy,
  output logic              done,
  output logic              timeout_err
);
  localparam int FRAME_W = 8 + 5 + PAGE_W + OFS_W + 1;
  localparam int BC_W    = $clog2(FRAME_W + 1);
  localparam int DIV_W   = $clog2(SCK_DIV + 1);
  localparam int TO_W    = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_DATA, S_COMMIT, S_BUSY} state_t;

  state_t             state;
  logic [FRAME_W-1:0] sreg, frame;
  logic [BC_W-1:0]    bits_left, frame_len;
  logic [DIV_W-1:0]   div_cnt;
  logic [TO_W-1:0]    tmr;
  logic               prog_q, data_ph, last_q;
  logic               sck_q, cs_q, done_q, err_q;

  wire tick = (div_cnt == DIV_W'(SCK_DIV - 1));
  wire [7:0] prog_op = req_buf ? 8'h85 : 8'h82;

  always_comb begin
    if (req_cmd[1]) begin
      frame     = {prog_op, 5'b0, req_page, req_offset, 1'b0};
      frame_len = BC_W'(FRAME_W);
    end else if (req_cmd[0]) begin
      frame     = {8'h50, 5'b0, req_page[PAGE_W-1:3], {(OFS_W + 4){1'b0}}};
      frame_len = BC_W'(FRAME_W - 1);
    end else begin
      frame     = {8'h81, 5'b0, req_page, {(OFS_W + 1){1'b0}}};
      frame_len = BC_W'(FRAME_W - 1);
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign dat_ready   = (state == S_DATA);
  assign spi_sck     = sck_q;
  assign spi_cs_n    = cs_q;
  assign spi_mosi    = sreg[FRAME_W-1];
  assign done        = done_q;
  assign timeout_err = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sreg      <= '0;
      bits_left <= '0;
      div_cnt   <= '0;
      tmr       <= '0;
      prog_q    <= 1'b0;
      data_ph   <= 1'b0;
      last_q    <= 1'b0;
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          sreg      <= frame;
          bits_left <= frame_len;
          prog_q    <= req_cmd[1];
          data_ph   <= 1'b0;
          last_q    <= 1'b0;
          cs_q      <= 1'b0;
          div_cnt   <= '0;
          state     <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          div_cnt <= '0;
          sck_q   <= ~sck_q;
          if (sck_q) begin
            bits_left <= bits_left - BC_W'(1);
            if (bits_left == BC_W'(1))
              state <= (prog_q && !(data_ph && last_q)) ? S_DATA : S_COMMIT;
            else
              sreg <= sreg << 1;
          end
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
        S_DATA: if (dat_valid) begin
          sreg      <= {dat_byte, {(FRAME_W - 8){1'b0}}};
          bits_left <= BC_W'(8);
          last_q    <= dat_last;
          data_ph   <= 1'b1;
          div_cnt   <= '0;
          state     <= S_SHIFT;
        end
        S_COMMIT: if (tick) begin
          cs_q    <= 1'b1;
          div_cnt <= '0;
          tmr     <= '0;
          state   <= S_BUSY;
        end else begin
          div_cnt <= div_cnt + DIV_W'(1);
        end
        S_BUSY: if (!flash_busy) begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end else if (tmr == TO_W'(TIMEOUT_CYCLES - 1)) begin
          err_q <= 1'b1;
          state <= S_IDLE;
        end else begin
          tmr <= tmr + TO_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  assert_mosi_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
  assert_data_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (!spi_cs_n && !spi_sck));
  assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !spi_cs_n));
  assert_done_after_idle_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(flash_busy) && spi_cs_n));
  assert_done_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout_err));
endmodule

// File: tb/test_flash_erase_prog_seq.sv
module test_flash_erase_prog_seq;
  localparam int TO = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_buf = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [9:0] req_page = '0;
  logic [8:0] req_offset = '0;
  logic dat_valid = 1'b0, dat_last = 1'b0;
  logic [7:0] dat_byte = '0;
  logic flash_busy = 1'b0;
  logic req_ready, dat_ready, spi_sck, spi_cs_n, spi_mosi, done, timeout_err;

  flash_erase_prog_seq #(.SCK_DIV(2), .TIMEOUT_CYCLES(TO)) i_flash_erase_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_page(req_page), .req_buf(req_buf), .req_offset(req_offset),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte), .dat_last(dat_last),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .flash_busy(flash_busy),
    .done(done), .timeout_err(timeout_err));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] dbytes [8];
  logic [127:0] cap;
  int ncap, nfall, mode_viol = 0;
  logic mosi_hi = 1'b0;
  int busy_len = 1, bcnt = 0, rel_cyc = 0, rise_cyc = 0;
  logic prev_cs = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge spi_sck) if (!spi_cs_n) begin
    cap = {cap[126:0], spi_mosi};
    ncap++;
    mosi_hi = spi_mosi;
  end
  always @(negedge spi_cs_n) nfall++;
  always @(negedge clk) begin
    if (spi_sck && spi_mosi !== mosi_hi) mode_viol++;
    if (spi_cs_n && !spi_sck && !prev_cs) begin
      bcnt = busy_len;
      rise_cyc = cyc;
    end else if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) rel_cyc = cyc;
    end
    flash_busy = (bcnt > 0);
    prev_cs = spi_cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_bits(input int cmd, input logic [9:0] page,
      input bit bsel, input logic [8:0] ofs, input int nb, output int len);
    logic [127:0] r;
    if (cmd >= 2) begin
      r = {95'b0, (bsel ? 8'h85 : 8'h82), 5'b0, page, ofs, 1'b0};
      len = 33;
      for (int i = 0; i < nb; i++) begin
        r = (r << 8) | {120'b0, dbytes[i]};
        len += 8;
      end
    end else if (cmd == 1) begin
      r = {96'b0, 8'h50, 5'b0, page[9:3], 12'b0};
      len = 32;
    end else begin
      r = {96'b0, 8'h81, 5'b0, page, 9'b0};
      len = 32;
    end
    return r;
  endfunction

  task automatic feed(input int nb);
    int idx = 0;
    bit fire = 0;
    while (idx < nb) begin
      @(negedge clk);
      if (fire) idx++;
      if (idx < nb) begin
        dat_valid = ($urandom % 3) != 0;
        dat_byte  = dbytes[idx];
        dat_last  = (idx == nb - 1);
      end else begin
        dat_valid = 1'b0;
        dat_last  = 1'b0;
      end
      fire = dat_valid && dat_ready;
    end
  endtask

  task automatic run_op(input int cmd, input logic [9:0] page, input bit bsel,
                        input logic [8:0] ofs, input int nb, input int blen);
    int len, ready_bad = 0, dr_bad = 0, done_cyc = -1, err_cyc = -1, n = 0;
    bit pulse_ok = 1;
    logic [127:0] exp;
    string tag;
    tag = (cmd >= 2) ? "R4" : (cmd == 1) ? "R3" : "R2";
    exp = exp_bits(cmd, page, bsel, ofs, nb, len);
    cap = '0; ncap = 0; nfall = 0; busy_len = blen;
    @(negedge clk);
    chk(req_ready === 1'b1, "R8", "ready before request", {127'b0, req_ready}, 1);
    req_valid = 1'b1; req_cmd = cmd[1:0]; req_page = page; req_buf = bsel; req_offset = ofs;
    @(negedge clk);
    req_valid = 1'b0;
    req_page = ~page;
    fork
      feed((cmd >= 2) ? nb : 0);
      begin
        while (n < 20000) begin
          if (done) begin done_cyc = cyc; break; end
          if (timeout_err) begin err_cyc = cyc; break; end
          if (req_ready) ready_bad++;
          if (cmd < 2 && dat_ready) dr_bad++;
          @(negedge clk);
          n++;
        end
      end
    join
    @(negedge clk);
    if (done || timeout_err) pulse_ok = 0;
    chk(ncap == len, tag, "bit count", ncap, len);
    chk(cap == exp, tag, "frame bits", cap, exp);
    chk(nfall == 1, "R7", "chip select windows", nfall, 1);
    chk(ready_bad == 0, "R8", "ready during operation", ready_bad, 0);
    chk(pulse_ok, "R9", "pulse longer than one cycle", {127'b0, pulse_ok}, 1);
    if (cmd < 2) chk(dr_bad == 0, "R6", "data ready during erase", dr_bad, 0);
    if (blen < TO) begin
      chk(done_cyc == rel_cyc + 1, "R9", "done cycle", done_cyc, rel_cyc + 1);
    end else begin
      chk(err_cyc >= 0 && done_cyc < 0, "R10", "error without done", err_cyc, 1);
      chk(err_cyc - rise_cyc == TO, "R10", "timeout delay", err_cyc - rise_cyc, TO);
      chk(req_ready === 1'b1, "R10", "idle after timeout", {127'b0, req_ready}, 1);
      while (flash_busy) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "spi idle",
        {126'b0, spi_cs_n, spi_sck}, 2);
    chk(req_ready === 1'b1 && dat_ready === 1'b0 && done === 1'b0 && timeout_err === 1'b0,
        "R1", "handshake idle", {124'b0, req_ready, dat_ready, done, timeout_err}, 8);
    rst_n = 1'b1;
    run_op(0, 10'h3FF, 0, 9'h000, 0, 5);
    run_op(0, 10'h000, 1, 9'h1FF, 0, 1);
    run_op(1, 10'h3FF, 0, 9'h000, 0, 7);
    run_op(1, 10'h007, 0, 9'h000, 0, 3);
    dbytes[0] = 8'hA5;
    run_op(2, 10'h155, 0, 9'h1FF, 1, 12);
    for (int i = 0; i < 6; i++) dbytes[i] = 8'h11 * (i + 1);
    run_op(2, 10'h2AA, 1, 9'h000, 6, 20);
    dbytes[0] = 8'h80; dbytes[1] = 8'h01;
    run_op(3, 10'h001, 1, 9'h100, 2, 4);
    run_op(0, 10'h123, 0, 9'h000, 0, TO + 20);
    for (int k = 0; k < 16; k++) begin
      int c, nb;
      c = $urandom % 4;
      nb = 1 + ($urandom % 6);
      for (int i = 0; i < 8; i++) dbytes[i] = 8'($urandom);
      run_op(c, 10'($urandom), 1'($urandom), 9'($urandom), nb, 1 + ($urandom % 40));
    end
    chk(mode_viol == 0, "R5", "mosi moved while sck high", mode_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule